// File: doc/BRIEF.md
# Byte-Wide Code Array Programming Sequencer

This block drives parallel programming of a small nonvolatile code store. For simulation the store is a register array, by default 4096 bytes. An external programmer sets a mode, an address and a data byte, then pulses an active-low program strobe.

The sequencer handles:
- single-byte programming;
- whole-array erase;
- verify reads of the array;
- a fixed three-byte identification read;
- programming of three protection flags.

Programming and erase time themselves. Their lengths are parameters counted in clock cycles. Completion can be observed in two ways. A ready output is low while an operation runs. In verify mode, reading the byte currently being programmed returns bit 7 inverted until the operation ends.

Programming can only clear bits. The stored value becomes the AND of the old byte and the new byte, so a byte can only be raised back to FFH by an erase. When the first two protection flags are both set, verify reads of the array are blocked. No port reads the flags back. An erase sets every byte to FFH and clears all three flags.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, `rdy_o` is 1 and every array byte reads FFH in verify mode.
- R2: In program mode (`mode_i`=1), a high-to-low transition of `prog_n_i` sampled on a clock edge captures `addr_i`/`data_i`. `rdy_o` is then 0 for exactly WRITE_CYCLES cycles. After that, verify reads return the new contents.
- R3: While a byte program runs, a verify read (`mode_i`=2) at the captured address returns the inverse of bit 7 of the captured data in bit 7, and the stored old bits in 6:0. Verify reads at any other address return stored contents.
- R4: A program operation stores the bitwise AND of the previous byte and the captured data.
- R5: In erase mode (`mode_i`=3), holding `prog_n_i` low for ERASE_HOLD consecutive sampled edges starts an erase. A shorter low pulse has no effect. `rdy_o` is then 0 for exactly 2^ADDR_W cycles, and afterwards every byte reads FFH.
- R6: An erase returns all three protection flags to the unprogrammed state, so verify reads are no longer blocked.
- R7: In identification mode (`mode_i`=4), the responses are:
  - address 030H reads 1EH;
  - address 031H reads 51H;
  - address 032H reads FFH when `hv_cfg_i`=1 and 05H when `hv_cfg_i`=0;
  - every other address reads FFH.
- R8: In flag mode (`mode_i`=5), a strobe sets each protection flag k whose bit `data_i[k]` (k=0..2) is 1. This is self-timed like R2. Once flags 0 and 1 are both set, verify reads return FFH. Either flag alone, or flag 2, does not block reads.
- R9: A falling strobe while `rdy_o` is 0 is ignored: it changes no byte and does not lengthen the running operation.
- R10: In modes 0, 1, 3, 5, 6 and 7, `data_o` is FFH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Operation select (0 none, 1 program, 2 verify, 3 erase, 4 identification, 5 flags) |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | DATA_W | Data to program, or flag-select mask |
| prog_n_i | input | 1 | Active-low program strobe |
| hv_cfg_i | input | 1 | Programming-voltage configuration, selects the third identification byte |
| data_o | output | DATA_W | Read data |
| rdy_o | output | 1 | 1 when idle, 0 while an operation runs |

## Verification
The assertions assume that all inputs are synchronous to `clk` and change only between rising edges. They also assume `mode_i` stays in program or flag mode on the edge where a strobe falls. Finally, they assume the strobe is released after an erase starts.

The bench drives every input on the falling clock edge. It changes mode only after the strobe is already captured. It releases the strobe on the first cycle `rdy_o` is seen low. Random programming uses a pool of eight addresses so that AND merging is exercised repeatedly. Directed cases cover the following:
- polling;
- a short erase pulse;
- a strobe injected during a busy period;
- each protection-flag combination.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    localparam logic [2:0] MODE_NONE      = 3'd0;
    localparam logic [2:0] MODE_PROGRAM   = 3'd1;
    localparam logic [2:0] MODE_VERIFY    = 3'd2;
    localparam logic [2:0] MODE_ERASE     = 3'd3;
    localparam logic [2:0] MODE_IDENT     = 3'd4;
    localparam logic [2:0] MODE_FLAGS     = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PGM   = 2'd1,
        ST_FLAG  = 2'd2,
        ST_ERASE = 2'd3
    } seq_state_e;

endpackage

// File: rtl/flash_prog_array.sv
module flash_prog_array #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_en_i,
    input  logic [ADDR_W-1:0] pgm_addr_i,
    input  logic [DATA_W-1:0] pgm_data_i,
    input  logic              fill_en_i,
    input  logic [ADDR_W-1:0] fill_addr_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] old_byte;

    assign old_byte  = mem[pgm_addr_i];
    assign rd_data_o = mem[rd_addr_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else begin
            if (pgm_en_i) begin
                mem[pgm_addr_i] <= old_byte & pgm_data_i;
            end
            if (fill_en_i) begin
                mem[fill_addr_i] <= '1;
            end
        end
    end

    AST_PROGRAM_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_en_i |=> ((mem[$past(pgm_addr_i)] & ~$past(old_byte)) == '0)); // R4

    AST_ERASE_FILLS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en_i |=> (mem[$past(fill_addr_i)] == '1)); // R5

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int DATA_W       = 8,
    parameter int LOCK_N       = 3,
    parameter int WRITE_CYCLES = 32,
    parameter int ERASE_HOLD   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              prog_n_i,
    output logic              pgm_en_o,
    output logic [ADDR_W-1:0] pgm_addr_o,
    output logic [DATA_W-1:0] pgm_data_o,
    output logic              fill_en_o,
    output logic [ADDR_W-1:0] fill_addr_o,
    output logic              rdy_o,
    output logic              poll_active_o,
    output logic [ADDR_W-1:0] poll_addr_o,
    output logic              poll_msb_o,
    output logic [LOCK_N-1:0] lock_o
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WC_W   = $clog2(WRITE_CYCLES + 1);
    localparam int CNT_W  = ((WC_W > ADDR_W) ? WC_W : ADDR_W) + 1;
    localparam int HOLD_W = $clog2(ERASE_HOLD + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [HOLD_W-1:0] hold;
        logic              prog;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LOCK_N-1:0] lock;
    } ctrl_t;

    ctrl_t q, d;
    logic  strobe_fall;

    assign strobe_fall = q.prog & ~prog_n_i;

    always_comb begin
        d         = q;
        d.prog    = prog_n_i;
        pgm_en_o  = 1'b0;
        fill_en_o = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (mode_i == MODE_ERASE && !prog_n_i) begin
                    if (q.hold == HOLD_W'(ERASE_HOLD - 1)) begin
                        d.st   = ST_ERASE;
                        d.cnt  = '0;
                        d.hold = '0;
                    end else begin
                        d.hold = q.hold + HOLD_W'(1);
                    end
                end else begin
                    d.hold = '0;
                    if (strobe_fall && (mode_i == MODE_PROGRAM || mode_i == MODE_FLAGS)) begin
                        d.st   = (mode_i == MODE_PROGRAM) ? ST_PGM : ST_FLAG;
                        d.cnt  = CNT_W'(WRITE_CYCLES - 1);
                        d.addr = addr_i;
                        d.data = data_i;
                    end
                end
            end
            ST_PGM, ST_FLAG: begin
                if (q.cnt == '0) begin
                    d.st = ST_IDLE;
                    if (q.st == ST_PGM) begin
                        pgm_en_o = 1'b1;
                    end else begin
                        d.lock = q.lock | q.data[LOCK_N-1:0];
                    end
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_ERASE: begin
                fill_en_o = 1'b1;
                if (q.cnt == CNT_W'(DEPTH - 1)) begin
                    d.st   = ST_IDLE;
                    d.lock = '0;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.prog <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign pgm_addr_o    = q.addr;
    assign pgm_data_o    = q.data;
    assign fill_addr_o   = q.cnt[ADDR_W-1:0];
    assign rdy_o         = (q.st == ST_IDLE);
    assign poll_active_o = (q.st == ST_PGM);
    assign poll_addr_o   = q.addr;
    assign poll_msb_o    = q.data[DATA_W-1];
    assign lock_o        = q.lock;

    AST_TIMED_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_PGM || q.st == ST_FLAG) && q.cnt != '0)
        |=> (q.st == $past(q.st) && q.cnt == $past(q.cnt) - CNT_W'(1))); // R2

    AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_o && q.prog && !prog_n_i && mode_i == MODE_PROGRAM) |=> !rdy_o); // R2

    AST_BUSY_IGNORES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> ($stable(q.addr) && $stable(q.data))); // R9

    AST_ERASE_CLEARS_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ERASE && q.cnt == CNT_W'(DEPTH - 1)) |=> (q.lock == '0 && rdy_o)); // R6

endmodule

// File: rtl/flash_prog_rdmux.sv
module flash_prog_rdmux
    import flash_prog_pkg::*;
#(
    parameter int              ADDR_W     = 12,
    parameter int              DATA_W     = 8,
    parameter int              LOCK_N     = 3,
    parameter logic [ADDR_W-1:0] ID_BASE  = 'h030,
    parameter logic [DATA_W-1:0] ID_MAKER = 'h1E,
    parameter logic [DATA_W-1:0] ID_PART  = 'h51,
    parameter logic [DATA_W-1:0] ID_HV    = 'hFF,
    parameter logic [DATA_W-1:0] ID_LV    = 'h05
) (
    input  logic [2:0]        mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              hv_cfg_i,
    input  logic [DATA_W-1:0] arr_data_i,
    input  logic              poll_active_i,
    input  logic [ADDR_W-1:0] poll_addr_i,
    input  logic              poll_msb_i,
    input  logic [LOCK_N-1:0] lock_i,
    output logic [DATA_W-1:0] data_o
);

    logic read_blocked;

    assign read_blocked = lock_i[0] & lock_i[1];

    always_comb begin
        data_o = '1;
        if (mode_i == MODE_VERIFY) begin
            if (read_blocked) begin
                data_o = '1;
            end else if (poll_active_i && addr_i == poll_addr_i) begin
                data_o = {~poll_msb_i, arr_data_i[DATA_W-2:0]};
            end else begin
                data_o = arr_data_i;
            end
        end else if (mode_i == MODE_IDENT) begin
            if (addr_i == ID_BASE) begin
                data_o = ID_MAKER;
            end else if (addr_i == ID_BASE + ADDR_W'(1)) begin
                data_o = ID_PART;
            end else if (addr_i == ID_BASE + ADDR_W'(2)) begin
                data_o = hv_cfg_i ? ID_HV : ID_LV;
            end
        end
    end

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
    parameter int ADDR_W       = 12,
    parameter int DATA_W       = 8,
    parameter int WRITE_CYCLES = 32,
    parameter int ERASE_HOLD   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              prog_n_i,
    input  logic              hv_cfg_i,
    output logic [DATA_W-1:0] data_o,
    output logic              rdy_o
);

    localparam int LOCK_N = 3;

    logic              pgm_en;
    logic [ADDR_W-1:0] pgm_addr;
    logic [DATA_W-1:0] pgm_data;
    logic              fill_en;
    logic [ADDR_W-1:0] fill_addr;
    logic              poll_active;
    logic [ADDR_W-1:0] poll_addr;
    logic              poll_msb;
    logic [LOCK_N-1:0] lock;
    logic [DATA_W-1:0] arr_data;

    flash_prog_ctrl #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .LOCK_N      (LOCK_N),
        .WRITE_CYCLES(WRITE_CYCLES),
        .ERASE_HOLD  (ERASE_HOLD)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_i),
        .addr_i       (addr_i),
        .data_i       (data_i),
        .prog_n_i     (prog_n_i),
        .pgm_en_o     (pgm_en),
        .pgm_addr_o   (pgm_addr),
        .pgm_data_o   (pgm_data),
        .fill_en_o    (fill_en),
        .fill_addr_o  (fill_addr),
        .rdy_o        (rdy_o),
        .poll_active_o(poll_active),
        .poll_addr_o  (poll_addr),
        .poll_msb_o   (poll_msb),
        .lock_o       (lock)
    );

    flash_prog_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .pgm_en_i   (pgm_en),
        .pgm_addr_i (pgm_addr),
        .pgm_data_i (pgm_data),
        .fill_en_i  (fill_en),
        .fill_addr_i(fill_addr),
        .rd_addr_i  (addr_i),
        .rd_data_o  (arr_data)
    );

    flash_prog_rdmux #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .LOCK_N(LOCK_N)
    ) u_rdmux (
        .mode_i       (mode_i),
        .addr_i       (addr_i),
        .hv_cfg_i     (hv_cfg_i),
        .arr_data_i   (arr_data),
        .poll_active_i(poll_active),
        .poll_addr_i  (poll_addr),
        .poll_msb_i   (poll_msb),
        .lock_i       (lock),
        .data_o       (data_o)
    );

endmodule

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb;

    localparam int AW    = 12;
    localparam int WC    = 32;
    localparam int EH    = 64;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode = 3'd0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdat = '0;
    logic          prog_n = 1'b1;
    logic          hv = 1'b1;
    logic [7:0]    rdat;
    logic          rdy;

    logic [7:0] model [DEPTH];
    logic [2:0] mlock;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    flash_prog_seq #(.ADDR_W(AW), .DATA_W(8), .WRITE_CYCLES(WC), .ERASE_HOLD(EH)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .addr_i(addr), .data_i(wdat),
        .prog_n_i(prog_n), .hv_cfg_i(hv), .data_o(rdat), .rdy_o(rdy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_verify(input logic [AW-1:0] a);
        return (mlock[0] && mlock[1]) ? 8'hFF : model[a];
    endfunction

    function automatic logic [7:0] exp_ident(input logic [AW-1:0] a, input logic h);
        if (a == 12'h030) return 8'h1E;
        if (a == 12'h031) return 8'h51;
        if (a == 12'h032) return h ? 8'hFF : 8'h05;
        return 8'hFF;
    endfunction

    task automatic read_chk(input string req, input logic [AW-1:0] a);
        @(negedge clk);
        mode = 3'd2; addr = a; #1;
        chk(req, rdat, exp_verify(a));
    endtask

    // timed operation (program or flags), optional polling or injected strobe
    task automatic timed_op(input logic [2:0] md, input logic [AW-1:0] a, input logic [7:0] d,
                            input bit poll, input bit inject, input logic [AW-1:0] ia);
        int k = 0;
        int busy = 0;
        @(negedge clk);
        mode = md; addr = a; wdat = d; prog_n = 1'b0;
        forever begin
            @(negedge clk);
            k++;
            if (k == 1) prog_n = 1'b1;
            if (inject && k == 2) begin mode = 3'd1; addr = ia; wdat = 8'h00; prog_n = 1'b0; end
            if (inject && k == 3) prog_n = 1'b1;
            if (poll && k == 1) begin mode = 3'd2; addr = a; end
            if (poll && k == 2) begin mode = 3'd2; addr = a ^ 12'h001; end
            #1;
            if (poll && k == 1 && md == 3'd1) // R3 polled byte
                chk("R3", rdat, (mlock[0] && mlock[1]) ? 8'hFF : {~d[7], model[a][6:0]});
            if (poll && k == 2) chk("R3", rdat, exp_verify(a ^ 12'h001)); // R3 other address
            if (rdy) break;
            busy++;
            if (k > WC + 10) break;
        end
        chk("R2", busy, WC);
        if (md == 3'd1) model[a] = model[a] & d;
        else mlock = mlock | d[2:0];
        mode = 3'd0; prog_n = 1'b1;
    endtask

    task automatic do_erase();
        int k = 0;
        int busy = 0;
        @(negedge clk);
        mode = 3'd3; prog_n = 1'b0;
        forever begin
            @(negedge clk); k++; #1;
            if (!rdy || k > EH + 10) break;
        end
        chk("R5", k, EH);
        prog_n = 1'b1;
        busy = 1;
        forever begin
            @(negedge clk); #1;
            if (rdy || busy > DEPTH + 10) break;
            busy++;
        end
        chk("R5", busy, DEPTH);
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        mlock = 3'b000;
        mode = 3'd0;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        mlock = 3'b000;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1", rdy, 1);
        for (int i = 0; i < 6; i++) read_chk("R1", AW'($urandom % DEPTH));
        read_chk("R1", 12'hFFF);
        @(negedge clk); mode = 3'd0; addr = 12'h123; #1;
        chk("R10", rdat, 8'hFF);

        // directed program with polling, then AND merge
        timed_op(3'd1, 12'h123, 8'hDA, 1'b1, 1'b0, '0);
        read_chk("R2", 12'h123);
        timed_op(3'd1, 12'h123, 8'hF3, 1'b1, 1'b0, '0);
        read_chk("R4", 12'h123);
        chk("R4", model[12'h123], 8'hD2);

        // strobe during busy is ignored
        timed_op(3'd1, 12'h040, 8'h0F, 1'b0, 1'b1, 12'h041);
        read_chk("R9", 12'h041);
        read_chk("R9", 12'h040);

        // random programming over a small pool
        for (int n = 0; n < 40; n++) begin
            logic [AW-1:0] a;
            a = 12'h200 + AW'($urandom % 8);
            timed_op(3'd1, a, 8'($urandom), ($urandom % 4) == 0, 1'b0, '0);
            read_chk("R4", 12'h200 + AW'($urandom % 8));
        end

        // identification
        for (int h = 1; h >= 0; h--) begin
            for (int a = 12'h02F; a <= 12'h033; a++) begin
                @(negedge clk); hv = h[0]; mode = 3'd4; addr = AW'(a); #1;
                chk("R7", rdat, exp_ident(AW'(a), h[0]));
            end
        end
        hv = 1'b1;
        for (int m = 5; m < 8; m++) begin
            @(negedge clk); mode = 3'(m); addr = 12'h123; #1;
            chk("R10", rdat, 8'hFF);
        end

        // short erase pulse has no effect
        @(negedge clk); mode = 3'd3; prog_n = 1'b0;
        repeat (EH - 1) @(negedge clk);
        prog_n = 1'b1;
        repeat (EH + 2) begin
            @(negedge clk); #1;
            if (!rdy) break;
        end
        chk("R5", rdy, 1);
        read_chk("R5", 12'h123);

        // protection flags
        timed_op(3'd5, '0, 8'h04, 1'b0, 1'b0, '0);
        read_chk("R8", 12'h123);
        chk("R8", rdat, 8'hD2);
        timed_op(3'd5, '0, 8'h01, 1'b0, 1'b0, '0);
        read_chk("R8", 12'h123);
        timed_op(3'd5, '0, 8'h02, 1'b0, 1'b0, '0);
        read_chk("R8", 12'h123);
        chk("R8", rdat, 8'hFF);
        @(negedge clk); mode = 3'd4; addr = 12'h031; #1;
        chk("R8", rdat, 8'h51);

        // full erase clears data and flags
        do_erase();
        read_chk("R5", 12'h123);
        read_chk("R5", 12'h040);
        for (int i = 0; i < 8; i++) read_chk("R5", 12'h200 + AW'(i));
        timed_op(3'd1, 12'h123, 8'h3C, 1'b0, 1'b0, '0);
        read_chk("R6", 12'h123);
        chk("R6", rdat, 8'h3C);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule